// File: doc/BRIEF.md
# YUV 4:2:2 to RGB Pixel Converter

This block turns a stream of packed 4:2:2 camera bytes into 24-bit RGB pixels. Bytes come in through a valid/ready port, four to a group, in the order U, Y0, V, Y1. Each group gives two pixels, one for each luma byte, and both pixels use the same chroma pair. A start-of-frame flag on the input marks the first byte of a frame. That flag comes out on the first pixel of that frame and stays lined up with the data.

Each colour channel is built in integer arithmetic with 8 fractional bits. Luma is scaled by 256, the chroma terms are multiplied by fixed integer coefficients, and a constant offset is added. The sum is then shifted down and clamped to the range 0..255. The work runs through three registered stages: products, sum, saturation. The whole pipeline stops when the output side is not ready, and nothing is lost.

Top module: `yuv_rgb_conv`

## Requirements
- R1: Bytes of a group are taken as U, Y0, V, Y1. Both pixels use that U and V. The Y0 pixel is output before the Y1 pixel. `out_rgb` carries red in bits [23:16], green in [15:8] and blue in [7:0].
- R2: Red comes from the signed sum 256*Y + 359*V - 45952.
- R3: Green comes from the signed sum 256*Y - 183*V - 88*U + 34688.
- R4: Blue comes from the signed sum 256*Y + 454*U - 58112.
- R5: Each channel is its sum shifted right by 8. A negative sum gives 0, and a shifted value of 256 or more gives 255.
- R6: The pipeline starts empty with `out_ready` high. The Y0 pixel then shows `out_valid` on the third clock edge after the edge that accepts Y1. The Y1 pixel follows on the next edge.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_rgb` and `out_sof` hold still. No pixel is dropped or reordered.
- R8: A byte accepted with `in_sof` high is always taken as the U byte of a new group. `out_sof` is high only on the Y0 pixel of that group.
- R9: When a new frame starts before the current group has all four bytes, the bytes already received for that group are dropped and produce no pixel.
- R10: During reset and on the cycle after it, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An input byte is offered |
| in_ready | output | 1 | The block can take the byte |
| in_data | input | 8 | Packed chroma or luma byte |
| in_sof | input | 1 | The byte starts a frame |
| out_valid | output | 1 | A pixel is offered |
| out_ready | input | 1 | The consumer takes the pixel |
| out_rgb | output | 24 | Pixel, red in the top byte |
| out_sof | output | 1 | The pixel is the first of a frame |

## Verification
Two things can happen in the same cycle. The unpacker can take a new group, or restart on a frame flag, while the output is stalled and the previous pair is still waiting. To make this happen, the bench sends the vector table a second time with a pseudo-random `out_ready`, and later holds `out_ready` low with a pair pending. It then checks that the held pixel does not change, that the count of pixels still owed stays at two, and that every pixel later arrives in order with the right frame flag. Truncated groups placed right before a frame start must add no pixels to the expected stream.

// File: rtl/yuv_rgb_pkg.sv
package yuv_rgb_pkg;
  localparam int PIX_W  = 8;
  localparam int FRAC_W = 8;
  localparam int NCH    = 3;
  localparam int LAT    = 3;
  localparam int RGB_W  = NCH * PIX_W;

  typedef enum logic [1:0] {
    SLOT_U  = 2'd0,
    SLOT_Y0 = 2'd1,
    SLOT_V  = 2'd2,
    SLOT_Y1 = 2'd3
  } slot_e;

  typedef struct packed {
    logic [PIX_W-1:0] u;
    logic [PIX_W-1:0] v;
    logic [PIX_W-1:0] y0;
    logic [PIX_W-1:0] y1;
    logic             sof;
  } group_t;

  typedef struct packed {
    logic [PIX_W-1:0] u;
    logic [PIX_W-1:0] v;
    logic [PIX_W-1:0] y;
    logic             sof;
  } beat_t;

  // channel 0 = red, 1 = green, 2 = blue
  localparam int signed GAIN_U [NCH] = '{0, -88, 454};
  localparam int signed GAIN_V [NCH] = '{359, -183, 0};
  localparam int signed OFFSET [NCH] = '{-45952, 34688, -58112};
endpackage

// File: rtl/yuv_rgb_unpack.sv
module yuv_rgb_unpack
  import yuv_rgb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_data,
  input  logic             in_sof,
  input  logic             take,
  output logic             beat_valid,
  output beat_t            beat
);
  slot_e            slot_q;
  slot_e            slot_eff;
  logic [PIX_W-1:0] col_u, col_v, col_y0;
  logic             col_sof;
  group_t           emit_q;
  logic [1:0]       left_q;
  logic             accept;

  // a group can only complete once the previous pair has left
  assign in_ready = !(slot_q == SLOT_Y1 && left_q != 2'd0);
  assign accept   = in_valid && in_ready;
  assign slot_eff = in_sof ? SLOT_U : slot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q  <= SLOT_U;
      col_u   <= '0;
      col_v   <= '0;
      col_y0  <= '0;
      col_sof <= 1'b0;
      emit_q  <= '0;
    end else if (accept) begin
      unique case (slot_eff)
        SLOT_U: begin
          col_u   <= in_data;
          col_sof <= in_sof;
          slot_q  <= SLOT_Y0;
        end
        SLOT_Y0: begin
          col_y0 <= in_data;
          slot_q <= SLOT_V;
        end
        SLOT_V: begin
          col_v  <= in_data;
          slot_q <= SLOT_Y1;
        end
        default: begin
          emit_q.u   <= col_u;
          emit_q.v   <= col_v;
          emit_q.y0  <= col_y0;
          emit_q.y1  <= in_data;
          emit_q.sof <= col_sof;
          slot_q     <= SLOT_U;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= 2'd0;
    end else if (accept && slot_eff == SLOT_Y1) begin
      left_q <= 2'd2;
    end else if (beat_valid && take) begin
      left_q <= left_q - 2'd1;
    end
  end

  assign beat_valid = (left_q != 2'd0);
  assign beat.u     = emit_q.u;
  assign beat.v     = emit_q.v;
  assign beat.y     = (left_q == 2'd2) ? emit_q.y0 : emit_q.y1;
  assign beat.sof   = emit_q.sof && (left_q == 2'd2);
endmodule

// File: rtl/yuv_rgb_chan.sv
module yuv_rgb_chan
  import yuv_rgb_pkg::*;
#(
  parameter int ACC_W  = 20,
  parameter int KU     = 0,
  parameter int KV     = 0,
  parameter int KBIAS  = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [PIX_W-1:0] y,
  input  logic [PIX_W-1:0] u,
  input  logic [PIX_W-1:0] v,
  output logic [PIX_W-1:0] pix
);
  localparam int PAD_Y = ACC_W - PIX_W - FRAC_W;
  localparam int PAD_C = ACC_W - PIX_W;
  localparam int TOP   = FRAC_W + PIX_W;
  localparam logic signed [ACC_W-1:0] KU_S = ACC_W'(KU);
  localparam logic signed [ACC_W-1:0] KV_S = ACC_W'(KV);
  localparam logic signed [ACC_W-1:0] KB_S = ACC_W'(KBIAS);

  logic signed [ACC_W-1:0] u_s, v_s;
  logic signed [ACC_W-1:0] py_q, pu_q, pv_q, sum_q;

  assign u_s = $signed({{PAD_C{1'b0}}, u});
  assign v_s = $signed({{PAD_C{1'b0}}, v});

  // stage 1: products
  always_ff @(posedge clk) begin
    if (rst) begin
      py_q <= '0;
      pu_q <= '0;
      pv_q <= '0;
    end else if (en) begin
      py_q <= $signed({{PAD_Y{1'b0}}, y, {FRAC_W{1'b0}}});
      pu_q <= u_s * KU_S;
      pv_q <= v_s * KV_S;
    end
  end

  // stage 2: sum with folded offset
  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q <= '0;
    end else if (en) begin
      sum_q <= py_q + pu_q + pv_q + KB_S;
    end
  end

  // stage 3: saturate to the pixel range
  always_ff @(posedge clk) begin
    if (rst) begin
      pix <= '0;
    end else if (en) begin
      if (sum_q[ACC_W-1]) begin
        pix <= '0;
      end else if (|sum_q[ACC_W-2:TOP]) begin
        pix <= '1;
      end else begin
        pix <= sum_q[TOP-1:FRAC_W];
      end
    end
  end
endmodule

// File: rtl/yuv_rgb_pipe.sv
module yuv_rgb_pipe
  import yuv_rgb_pkg::*;
#(
  parameter int ACC_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             beat_valid,
  input  beat_t            beat,
  output logic             take,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [RGB_W-1:0] out_rgb,
  output logic             out_sof
);
  logic           en;
  logic [LAT-1:0] vld_q;
  logic [LAT-1:0] sof_q;

  assign en   = !vld_q[LAT-1] || out_ready;
  assign take = en;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      sof_q <= '0;
    end else if (en) begin
      vld_q <= {vld_q[LAT-2:0], beat_valid};
      sof_q <= {sof_q[LAT-2:0], beat_valid && beat.sof};
    end
  end

  assign out_valid = vld_q[LAT-1];
  assign out_sof   = sof_q[LAT-1];

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    yuv_rgb_chan #(
      .ACC_W (ACC_W),
      .KU    (GAIN_U[g]),
      .KV    (GAIN_V[g]),
      .KBIAS (OFFSET[g])
    ) u_chan (
      .clk (clk),
      .rst (rst),
      .en  (en),
      .y   (beat.y),
      .u   (beat.u),
      .v   (beat.v),
      .pix (out_rgb[(NCH-1-g)*PIX_W +: PIX_W])
    );
  end
endmodule

// File: rtl/yuv_rgb_conv.sv
module yuv_rgb_conv
  import yuv_rgb_pkg::*;
#(
  parameter int ACC_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_data,
  input  logic             in_sof,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [RGB_W-1:0] out_rgb,
  output logic             out_sof
);
  beat_t beat;
  logic  beat_valid;
  logic  take;

  yuv_rgb_unpack u_unpack (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .in_sof     (in_sof),
    .take       (take),
    .beat_valid (beat_valid),
    .beat       (beat)
  );

  yuv_rgb_pipe #(.ACC_W(ACC_W)) u_pipe (
    .clk        (clk),
    .rst        (rst),
    .beat_valid (beat_valid),
    .beat       (beat),
    .take       (take),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_rgb    (out_rgb),
    .out_sof    (out_sof)
  );
endmodule

// File: rtl/yuv_rgb_conv_chk.sv
module yuv_rgb_conv_chk
  import yuv_rgb_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [RGB_W-1:0] out_rgb,
  input logic             out_sof
);
  logic odd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      odd_q <= 1'b0;
    end else if (out_valid && out_ready) begin
      odd_q <= !odd_q;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_rgb) && $stable(out_sof))
    else $error("stalled pixel changed"); // R7

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> !out_valid && in_ready)
    else $error("not idle after reset"); // R10

  AST_SOF_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> out_valid)
    else $error("frame flag without pixel"); // R8

  AST_SOF_ON_EVEN: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_sof |-> !odd_q)
    else $error("frame flag on second pixel of a pair"); // R8
endmodule

bind yuv_rgb_conv yuv_rgb_conv_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_rgb   (out_rgb),
  .out_sof   (out_sof)
);

// File: tb/yuv_rgb_conv_bench.sv
module yuv_rgb_conv_bench;
  localparam int NVEC = 8;
  // packed as {U, Y0, V, Y1}
  localparam logic [31:0] VEC [NVEC] = '{
    32'h8010_80EB, 32'h0000_0000, 32'hFFFF_FFFF, 32'h5A51_F052,
    32'hF029_6E2A, 32'h3691_2290, 32'h10EB_F0EB, 32'hC040_20B0
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_sof = 1'b0;
  logic [7:0]  in_data = 8'd0;
  logic        out_ready = 1'b1;
  logic        in_ready, out_valid, out_sof;
  logic [23:0] out_rgb;

  int          tests = 0;
  int          fails = 0;
  int          rmode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [24:0] expq [256];
  int          exp_wr = 0;
  int          exp_rd = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  yuv_rgb_conv u_yuv_rgb_conv (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_sof    (in_sof),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_rgb   (out_rgb),
    .out_sof   (out_sof)
  );

  function automatic logic [7:0] sat8(input int acc);
    if (acc < 0) return 8'd0;
    if ((acc >>> 8) > 255) return 8'hFF;
    return 8'(acc >>> 8);
  endfunction

  // R2 R3 R4 R5 from the stated sums
  function automatic logic [23:0] model(input logic [7:0] u, input logic [7:0] y, input logic [7:0] v);
    int r, g, b;
    r = int'(y) * 256 + 359 * int'(v) - 45952;
    g = int'(y) * 256 - 183 * int'(v) - 88 * int'(u) + 34688;
    b = int'(y) * 256 + 454 * int'(u) - 58112;
    return {sat8(r), sat8(g), sat8(b)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (rmode)
      1:       out_ready = lfsr[0] | lfsr[3];
      2:       out_ready = 1'b0;
      default: out_ready = 1'b1;
    endcase
  end

  // output monitor: order, values and frame flag (R1 R2 R3 R4 R5 R7 R8 R9)
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      tests++;
      if (exp_rd == exp_wr) begin
        fails++;
        $display("FAIL R9: actual pixel %h sof %b expected none", out_rgb, out_sof);
      end else begin
        if ({out_sof, out_rgb} !== expq[exp_rd % 256]) begin
          fails++;
          $display("FAIL R1/R2/R3/R4/R5/R8: actual %h expected %h",
                   {out_sof, out_rgb}, expq[exp_rd % 256]);
        end
        exp_rd++;
      end
    end
  end

  task automatic send(input logic [7:0] d, input logic s);
    in_data  = d;
    in_sof   = s;
    in_valid = 1'b1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk);
    #2;
  endtask

  task automatic send_group(input logic [31:0] w, input logic s);
    expq[exp_wr % 256] = {s, model(w[31:24], w[23:16], w[15:8])};
    exp_wr++;
    expq[exp_wr % 256] = {1'b0, model(w[31:24], w[7:0], w[15:8])};
    exp_wr++;
    send(w[31:24], s);
    send(w[23:16], 1'b0);
    send(w[15:8], 1'b0);
    send(w[7:0], 1'b0);
  endtask

  task automatic drain();
    int n;
    n = 0;
    in_valid = 1'b0;
    while (exp_rd != exp_wr && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(exp_rd == exp_wr, "R7", 32'(exp_rd), 32'(exp_wr));
    @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R10", 32'(out_valid), 32'd0);
    chk(in_ready == 1'b1, "R10", 32'(in_ready), 32'd1);
    @(posedge clk);
    #2;
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R10", {out_valid, in_ready}, 32'd1);
    @(posedge clk);
    #2;

    // R6: latency from the accepting edge of Y1
    send_group(VEC[0], 1'b1);
    in_valid = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      if (k == 3) chk(out_valid == 1'b0, "R6", 32'(out_valid), 32'd0);
      if (k == 4) chk(out_valid == 1'b1, "R6", 32'(out_valid), 32'd1);
      if (k == 5) chk(out_valid == 1'b1, "R6", 32'(out_valid), 32'd1);
    end
    @(posedge clk);
    #2;
    drain();

    // table walk, free-flowing output
    for (int i = 0; i < NVEC; i++) send_group(VEC[i], i == 0);
    drain();

    // same table under random backpressure (R7)
    rmode = 1;
    for (int i = 0; i < NVEC; i++) send_group(VEC[i], i == 0);
    for (int i = 0; i < NVEC; i++) send_group(VEC[NVEC-1-i], 1'b0);
    drain();
    rmode = 0;

    // R9: truncated groups before a frame start yield nothing
    send(8'h11, 1'b1);
    send(8'h22, 1'b0);
    send_group(VEC[3], 1'b1);
    send(8'h33, 1'b1);
    send(8'h44, 1'b0);
    send(8'h55, 1'b0);
    send_group(VEC[4], 1'b1);
    send_group(VEC[5], 1'b0);
    send(8'h66, 1'b0);
    send(8'h77, 1'b1);
    send_group(VEC[2], 1'b1);
    drain();

    // R7: held output stays put and nothing is consumed
    rmode = 2;
    @(posedge clk);
    #2;
    send_group(VEC[6], 1'b1);
    in_valid = 1'b0;
    repeat (8) @(negedge clk);
    chk(out_valid == 1'b1, "R7", 32'(out_valid), 32'd1);
    chk({out_sof, out_rgb} == {1'b1, model(VEC[6][31:24], VEC[6][23:16], VEC[6][15:8])},
        "R7", {out_sof, out_rgb}, {1'b1, model(VEC[6][31:24], VEC[6][23:16], VEC[6][15:8])});
    chk(exp_wr - exp_rd == 2, "R7", 32'(exp_wr - exp_rd), 32'd2);
    @(posedge clk);
    #2;
    rmode = 0;
    drain();

    chk(exp_rd == exp_wr, "R9", 32'(exp_rd), 32'(exp_wr));
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R7: actual run still busy expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule